// File: doc/BRIEF.md
# Set/Clear Interrupt Enable Register

This block holds the 32-bit interrupt enable word of a host controller's register file and turns it, together with an incoming 32-bit interrupt event vector, into one level-sensitive interrupt line. Software never writes the word directly. It writes ones through one of two aliases: one alias sets the selected bits and the other clears them, so no read-modify-write is needed. A read through either alias returns the current word.

Each bit has a fixed access kind. Most bits can be set and cleared by software and can also be loaded by hardware. Bit 30 can only be changed by software. Bits 7 and 6 can only be changed by hardware. The reserved bits always hold zero. Bit 31 is the master enable that gates every source. Bits 30 to 0 line up with the event bits at the same positions. The interrupt output is registered.

Top module: `irq_enable_reg`

## Requirements
- R1: A write at address 0x88 sets every software-writable bit (31, 30, 26–19, 17–16, 9–8, 5–0) whose data bit is 1. Bits written with 0 keep their value.
- R2: A write at address 0x8C clears every software-writable bit whose data bit is 1. Bits written with 0 keep their value.
- R3: Bits 29–27, 18 and 15–10 always read as 0. They ignore software writes and hardware update strobes.
- R4: Bits 7 and 6 do not change on a software write at either alias. Only a hardware update changes them.
- R5: While bit 31 of the enable word is 0, the interrupt output is 0 whatever the events and the other enables hold.
- R6: The interrupt output is registered. One clock after an edge it equals bit 31 AND the OR over i in 0..30 of (event[i] AND enable[i]).
- R7: When hw_upd_stb[i] is 1 and bit i is hardware-updatable (31, 26–19, 17–16, 9–0), bit i takes hw_upd_val[i] and this overrides a software write to that bit in the same cycle. A strobe on bit 30 or on a reserved bit has no effect.
- R8: When bus_vld=1 and bus_wr=0, bus_rdata returns the enable word if bus_addr is 0x88 or 0x8C and returns 0 at any other address. bus_rdata is 0 when no read is in progress.
- R9: Reset (rst_n=0) clears every enable bit and the interrupt output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_vld | input | 1 | Register access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| hw_upd_stb | input | 32 | Per-bit hardware update strobe |
| hw_upd_val | input | 32 | Hardware update values |
| evt_vec | input | 32 | Interrupt event vector |
| irq | output | 1 | Level interrupt output |

## Verification
The bench targets a hardware strobe and a software clear that hit the same bit in the same cycle. A design that let software win would lose the hardware value. It writes all ones through both aliases. A design with a wrong access table would then let a reserved bit read as 1, or let bits 7–6 follow software. It also drives bit 31 on and off while events are active. Getting the latency wrong would show the interrupt one cycle early or late, and a leak through the master gate would raise it while bit 31 is 0. A read at an unrelated address must return zero, which catches a decoder that compares too few address bits.

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int           AW       = 8,
  parameter logic [AW-1:0] SET_ADDR = 8'h88,
  parameter logic [AW-1:0] CLR_ADDR = 8'h8C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_vld,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [31:0]   hw_upd_stb,
  input  logic [31:0]   hw_upd_val,
  input  logic [31:0]   evt_vec,
  output logic          irq
);

  localparam logic [31:0] SW_BITS = 32'hC7FB_033F;
  localparam logic [31:0] HW_BITS = 32'h87FB_03FF;
  localparam logic [31:0] RSV_BITS = ~(SW_BITS | HW_BITS);

  logic [31:0] en_q, sw_set, sw_clr, hw_sel, en_d;
  logic        hit_set, hit_clr;

  assign hit_set = bus_vld && bus_wr && (bus_addr == SET_ADDR);
  assign hit_clr = bus_vld && bus_wr && (bus_addr == CLR_ADDR);
  assign sw_set  = hit_set ? (bus_wdata & SW_BITS) : '0;
  assign sw_clr  = hit_clr ? (bus_wdata & SW_BITS) : '0;
  assign hw_sel  = hw_upd_stb & HW_BITS;
  assign en_d    = ((((en_q | sw_set) & ~sw_clr) & ~hw_sel) | (hw_upd_val & hw_sel)) & ~RSV_BITS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      irq  <= 1'b0;
    end else begin
      en_q <= en_d;
      irq  <= en_q[31] && |(evt_vec[30:0] & en_q[30:0]);
    end
  end

  assign bus_rdata = (bus_vld && !bus_wr && (bus_addr == SET_ADDR || bus_addr == CLR_ADDR)) ? en_q : '0;

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & RSV_BITS) == 32'h0);

  a_r4_sw_cannot_touch_7_6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_upd_stb[7:6] == 2'b00) |=> (en_q[7:6] == $past(en_q[7:6])));

  a_r5_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[31] |=> !irq);

  a_r7_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_upd_stb[0] |=> (en_q[0] == $past(hw_upd_val[0])));

  a_r2_clear_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && bus_wr && bus_addr == CLR_ADDR && bus_wdata[0] && !hw_upd_stb[0]) |=> !en_q[0]);

  a_r8_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_vld |-> (bus_rdata == 32'h0));

endmodule

// File: tb/irq_enable_reg_tb_top.sv
`timescale 1ns/1ps
module irq_enable_reg_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        bus_vld = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, hw_upd_stb = 0, hw_upd_val = 0, evt_vec = 0;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m = 0, last_rd;
  logic        m_irq = 0, last_irq;

  always #2 clk = ~clk;

  irq_enable_reg dut_i (.clk, .rst_n, .bus_vld, .bus_wr, .bus_addr, .bus_wdata,
    .bus_rdata, .hw_upd_stb, .hw_upd_val, .evt_vec, .irq);

  // 0 = reserved, 1 = sw only, 2 = hw only, 3 = sw and hw
  function automatic int kind(int i);
    if (i == 31) return 3;
    if (i == 30) return 1;
    if ((i >= 27 && i <= 29) || i == 18 || (i >= 10 && i <= 15)) return 0;
    if (i == 7 || i == 6) return 2;
    return 3;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, bit w, logic [7:0] a, logic [31:0] wd,
                      logic [31:0] st, logic [31:0] hv, logic [31:0] ev);
    logic [31:0] nm;
    bit any;
    bus_vld = v; bus_wr = w; bus_addr = a; bus_wdata = wd;
    hw_upd_stb = st; hw_upd_val = hv; evt_vec = ev;
    #1;
    last_rd = bus_rdata; last_irq = irq;
    chk("R8 read data", bus_rdata, (v && !w && (a == 8'h88 || a == 8'h8C)) ? m : 32'h0);
    chk("R6 irq", {31'h0, irq}, {31'h0, m_irq});
    @(posedge clk);
    nm = m; any = 0;
    for (int i = 0; i < 32; i++) begin
      int k = kind(i);
      if (i < 31 && ev[i] && m[i]) any = 1;
      if (v && w && wd[i] && (k == 1 || k == 3)) begin
        if (a == 8'h88) nm[i] = 1'b1;
        if (a == 8'h8C) nm[i] = 1'b0;
      end
      if (st[i] && (k == 2 || k == 3)) nm[i] = hv[i];
      if (k == 0) nm[i] = 1'b0;
    end
    m_irq = m[31] && any;
    m = nm;
    @(negedge clk);
  endtask

  task automatic idle(logic [31:0] ev); step(0, 0, 8'h0, 0, 0, 0, ev); endtask
  task automatic wr(logic [7:0] a, logic [31:0] d); step(1, 1, a, d, 0, 0, 0); endtask
  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    step(1, 0, a, 0, 0, 0, 0);
    chk(tag, last_rd, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 irq in reset", {31'h0, irq}, 32'h0);
    rst_n = 1;
    rd(8'h88, 32'h0, "R9 reset value");
    wr(8'h88, 32'hFFFF_FFFF);
    rd(8'h8C, 32'hC7FB_033F, "R1 set all");
    chk("R3 reserved read zero", last_rd & 32'h3804_FC00, 32'h0);
    chk("R4 bits 7:6 not set by sw", last_rd & 32'h0000_00C0, 32'h0);
    wr(8'h88, 32'h0);
    rd(8'h88, 32'hC7FB_033F, "R1 zero write keeps");
    wr(8'h8C, 32'h4000_0001);
    rd(8'h88, 32'h87FB_033E, "R2 clear selected");
    step(1, 1, 8'h8C, 32'hFFFF_FFFF, 32'h0000_00C1, 32'h0000_00C1, 0);
    rd(8'h88, 32'h0000_00C1, "R7 hw beats sw clear");
    step(0, 0, 8'h0, 0, 32'h4004_0000, 32'h4004_0000, 0);
    rd(8'h88, 32'h0000_00C1, "R7 no hw path bit 30 / R3 bit 18");
    wr(8'h8C, 32'h0000_00C0);
    rd(8'h8C, 32'h0000_00C1, "R4 sw clear ignored on 7:6");
    rd(8'h90, 32'h0, "R8 other address");
    idle(32'h1); idle(32'h1);
    chk("R5 master off gates", {31'h0, last_irq}, 32'h0);
    step(1, 1, 8'h88, 32'h8000_0000, 0, 0, 32'h1);
    idle(32'h1);
    chk("R6 one cycle latency", {31'h0, last_irq}, 32'h0);
    idle(32'h1);
    chk("R6 irq asserted", {31'h0, last_irq}, 32'h1);
    idle(32'h2); idle(32'h2);
    chk("R6 unmasked event only", {31'h0, last_irq}, 32'h0);
    wr(8'h88, 32'h4000_0000);
    idle(32'h4000_0000); idle(32'h4000_0000);
    chk("R6 bit 30 source", {31'h0, last_irq}, 32'h1);
    step(1, 1, 8'h8C, 32'h8000_0000, 0, 0, 32'h4000_0001);
    idle(32'h4000_0001); idle(32'h4000_0001);
    chk("R5 master cleared", {31'h0, last_irq}, 32'h0);
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      int s = $urandom_range(0, 2);
      a = (s == 0) ? 8'h88 : (s == 1) ? 8'h8C : 8'h90;
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a, $urandom,
           ($urandom_range(0, 3) == 0) ? $urandom : 32'h0, $urandom,
           $urandom & $urandom & $urandom);
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hang expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule